// File: doc/BRIEF.md
# Shadow-Stack-Aware Leaf Permission Checker

This block decides whether a memory access may use a leaf translation entry. It takes the entry's read, write and execute bits, the kind of access, and three mode flags: whether the access comes from a shadow-stack instruction, whether the lookup is a first-stage lookup, and whether shadow stacks are turned on. It returns the rights the entry grants, whether the entry is a shadow-stack page, a grant bit and a fault class.

The write-only encoding, which is otherwise reserved, becomes a shadow-stack page when shadow stacks are on and the lookup is first-stage. On such a page, shadow-stack instructions may read and write, and ordinary accesses may only read. A refused access on such a page is reported as an access fault, not a page fault. Every shadow-stack access is judged as a store.

One check is accepted per valid/ready transfer on the request side. The result, with the request's tag, is held in a single output register until the consumer takes it.

Top module: `sstk_perm_unit`

## Requirements
- R1: Entry bits {R,W,X}=010 form a shadow-stack page (out_ss_page=1) only when in_ss_en and in_first_stage are both 1. Otherwise the encoding is reserved: page fault, out_ss_page=0, out_rights=000.
- R2: Entry bits {R,W,X}=011 are always reserved and give a page fault with out_rights=000, whatever the mode flags.
- R3: On a shadow-stack page, a shadow-stack access gets out_rights=110 (read and write), and an ordinary access gets out_rights=100 (read only).
- R4: When in_ss_acc is 1, the request is judged as a store and needs the W right, whatever in_acc says.
- R5: A shadow-stack access to a read-only entry ({R,W,X}=100) gives a page fault.
- R6: On a shadow-stack page, a refused access gives an access fault. An ordinary store or fetch there is refused.
- R7: An ordinary load from a shadow-stack page is granted.
- R8: All other encodings pass {R,W,X} to out_rights unchanged. in_acc codes are 00 fetch (needs X), 01 load (needs R), 10 store (needs W), and 11 is judged as a store. A missing right gives a page fault.
- R9: out_fault is one-hot: 001 none, 010 page fault, 100 access fault. out_grant is 1 exactly when out_fault is 001.
- R10: A request is taken when in_valid and in_ready are both high. Its result and tag appear on the outputs with out_valid one cycle later. They are held unchanged while out_ready is low. in_ready is high when the output register is empty or is being emptied in the same cycle.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_pte_rwx | input | 3 | Leaf entry bits {R,W,X} |
| in_acc | input | 2 | Nominal access kind |
| in_ss_acc | input | 1 | Access issued by a shadow-stack instruction |
| in_first_stage | input | 1 | Lookup is first-stage |
| in_ss_en | input | 1 | Shadow stacks enabled |
| in_tag | input | TAG_W | Request tag, returned with the result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_rights | output | 3 | Effective rights {R,W,X} |
| out_ss_page | output | 1 | Entry is a shadow-stack page |
| out_fault | output | 3 | One-hot fault class |
| out_grant | output | 1 | Access permitted |
| out_tag | output | TAG_W | Tag of the request this result belongs to |

## Verification
A bad entry classification shows up in the first result after the request is taken. It appears either as a wrong out_ss_page bit or as a page fault where an access fault was due, which is the distinction shadow-stack handling depends on. A wrong choice of which access kind is judged shows as a wrong grant for shadow-stack loads and fetches. A broken output register shows while out_ready is held low: the result or tag changes, or out_valid drops before the result is taken.

// File: rtl/sstk_perm_pkg.sv
package sstk_perm_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ENC_PLAIN,
    ENC_SS_PAGE,
    ENC_RESERVED,
    ENC_SS_TO_RO
  } enc_class_e;

  localparam int RIGHTS_W = 3;
  localparam int FAULT_W  = 3;
  localparam int ACC_W    = 2;

  localparam logic [FAULT_W-1:0] FLT_NONE   = 3'b001;
  localparam logic [FAULT_W-1:0] FLT_PAGE   = 3'b010;
  localparam logic [FAULT_W-1:0] FLT_ACCESS = 3'b100;

  localparam logic [RIGHTS_W-1:0] RW_R_ONLY  = 3'b100;
  localparam logic [RIGHTS_W-1:0] RW_W_ONLY  = 3'b010;
  localparam logic [RIGHTS_W-1:0] RW_WX      = 3'b011;
  localparam logic [RIGHTS_W-1:0] RW_RW      = 3'b110;
  localparam logic [RIGHTS_W-1:0] RW_NONE    = 3'b000;

  // Access kind actually judged: shadow-stack work always counts as a store.
  function automatic acc_e judged_kind(input acc_e nominal, input logic ss_acc);
    if (ss_acc || nominal == ACC_ALT) return ACC_STORE;
    return nominal;
  endfunction

  // Right bit that a judged access kind needs, in {R,W,X} order.
  function automatic logic [RIGHTS_W-1:0] needed_right(input acc_e kind);
    case (kind)
      ACC_FETCH: return 3'b001;
      ACC_LOAD:  return 3'b100;
      default:   return 3'b010;
    endcase
  endfunction

  // Fault class for a refused access, chosen by the page class.
  function automatic logic [FAULT_W-1:0] refusal_fault(input enc_class_e cls);
    return (cls == ENC_SS_PAGE) ? FLT_ACCESS : FLT_PAGE;
  endfunction

endpackage

// File: rtl/sstk_enc_classify.sv
module sstk_enc_classify
  import sstk_perm_pkg::*;
(
  input  logic [RIGHTS_W-1:0] rwx,
  input  logic                ss_acc,
  input  logic                first_stage,
  input  logic                ss_en,
  output enc_class_e          enc_class,
  output logic [RIGHTS_W-1:0] rights
);

  logic ss_mode_on;
  assign ss_mode_on = ss_en && first_stage;

  always_comb begin
    enc_class = ENC_PLAIN;
    rights    = rwx;
    unique case (rwx)
      RW_WX: begin
        enc_class = ENC_RESERVED;
        rights    = RW_NONE;
      end
      RW_W_ONLY: begin
        if (ss_mode_on) begin
          enc_class = ENC_SS_PAGE;
          rights    = ss_acc ? RW_RW : RW_R_ONLY;
        end else begin
          enc_class = ENC_RESERVED;
          rights    = RW_NONE;
        end
      end
      RW_R_ONLY: begin
        if (ss_acc) enc_class = ENC_SS_TO_RO;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sstk_access_judge.sv
module sstk_access_judge
  import sstk_perm_pkg::*;
(
  input  enc_class_e          enc_class,
  input  logic [RIGHTS_W-1:0] rights,
  input  acc_e                nominal,
  input  logic                ss_acc,
  output acc_e                eff_kind,
  output logic                grant,
  output logic [FAULT_W-1:0]  fault
);

  logic right_held;

  always_comb begin
    eff_kind   = judged_kind(nominal, ss_acc);
    right_held = |(rights & needed_right(eff_kind));
    grant      = 1'b0;
    fault      = FLT_PAGE;
    case (enc_class)
      ENC_RESERVED, ENC_SS_TO_RO: begin
        grant = 1'b0;
        fault = FLT_PAGE;
      end
      default: begin
        grant = right_held;
        fault = right_held ? FLT_NONE : refusal_fault(enc_class);
      end
    endcase
  end

endmodule

// File: rtl/sstk_result_stage.sv
module sstk_result_stage
  import sstk_perm_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                drain,
  input  logic [RIGHTS_W-1:0] d_rights,
  input  logic                d_ss_page,
  input  logic [FAULT_W-1:0]  d_fault,
  input  logic                d_grant,
  input  logic [TAG_W-1:0]    d_tag,
  output logic                q_valid,
  output logic [RIGHTS_W-1:0] q_rights,
  output logic                q_ss_page,
  output logic [FAULT_W-1:0]  q_fault,
  output logic                q_grant,
  output logic [TAG_W-1:0]    q_tag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_rights  <= '0;
      q_ss_page <= 1'b0;
      q_fault   <= FLT_NONE;
      q_grant   <= 1'b0;
      q_tag     <= '0;
    end else if (take) begin
      q_valid   <= 1'b1;
      q_rights  <= d_rights;
      q_ss_page <= d_ss_page;
      q_fault   <= d_fault;
      q_grant   <= d_grant;
      q_tag     <= d_tag;
    end else if (drain) begin
      q_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/sstk_perm_unit.sv
module sstk_perm_unit
  import sstk_perm_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_pte_rwx,
  input  logic [1:0]          in_acc,
  input  logic                in_ss_acc,
  input  logic                in_first_stage,
  input  logic                in_ss_en,
  input  logic [TAG_W-1:0]    in_tag,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2:0]          out_rights,
  output logic                out_ss_page,
  output logic [2:0]          out_fault,
  output logic                out_grant,
  output logic [TAG_W-1:0]    out_tag
);

  // Named internal events, visible to the bound checker.
  enc_class_e          w_class;
  logic [RIGHTS_W-1:0] w_rights;
  acc_e                w_eff_kind;
  logic                w_grant;
  logic [FAULT_W-1:0]  w_fault;
  logic                w_take;
  logic                w_drain;

  assign w_drain  = out_valid && out_ready;
  assign in_ready = !out_valid || out_ready;
  assign w_take   = in_valid && in_ready;

  sstk_enc_classify u_classify (
    .rwx         (in_pte_rwx),
    .ss_acc      (in_ss_acc),
    .first_stage (in_first_stage),
    .ss_en       (in_ss_en),
    .enc_class   (w_class),
    .rights      (w_rights)
  );

  sstk_access_judge u_judge (
    .enc_class (w_class),
    .rights    (w_rights),
    .nominal   (acc_e'(in_acc)),
    .ss_acc    (in_ss_acc),
    .eff_kind  (w_eff_kind),
    .grant     (w_grant),
    .fault     (w_fault)
  );

  sstk_result_stage #(.TAG_W(TAG_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (w_take),
    .drain     (w_drain),
    .d_rights  (w_rights),
    .d_ss_page (w_class == ENC_SS_PAGE),
    .d_fault   (w_fault),
    .d_grant   (w_grant),
    .d_tag     (in_tag),
    .q_valid   (out_valid),
    .q_rights  (out_rights),
    .q_ss_page (out_ss_page),
    .q_fault   (out_fault),
    .q_grant   (out_grant),
    .q_tag     (out_tag)
  );

endmodule

// File: rtl/sstk_perm_checker.sv
module sstk_perm_checker
  import sstk_perm_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_pte_rwx,
  input logic             in_ss_acc,
  input logic             in_first_stage,
  input logic             in_ss_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       out_rights,
  input logic             out_ss_page,
  input logic [2:0]       out_fault,
  input logic             out_grant,
  input logic [TAG_W-1:0] out_tag
);

  logic taken;
  assign taken = in_valid && in_ready;

  assert_fault_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_fault) == 1);

  assert_grant_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_grant == (out_fault == FLT_NONE)));

  assert_sspage_no_pf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ss_page) |-> out_fault != FLT_PAGE);

  assert_sspage_rights_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ss_page) |-> (out_rights[2] && !out_rights[0]));

  assert_wx_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_pte_rwx == 3'b011) |=> (out_fault == FLT_PAGE && !out_grant));

  assert_wonly_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_pte_rwx == 3'b010 && !(in_ss_en && in_first_stage))
      |=> (out_fault == FLT_PAGE && !out_ss_page));

  assert_ss_to_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_pte_rwx == 3'b100 && in_ss_acc) |=> out_fault == FLT_PAGE);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_fault) &&
      $stable(out_rights) && $stable(out_tag) && $stable(out_ss_page)));

endmodule

bind sstk_perm_unit sstk_perm_checker #(.TAG_W(TAG_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_pte_rwx     (in_pte_rwx),
  .in_ss_acc      (in_ss_acc),
  .in_first_stage (in_first_stage),
  .in_ss_en       (in_ss_en),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_rights     (out_rights),
  .out_ss_page    (out_ss_page),
  .out_fault      (out_fault),
  .out_grant      (out_grant),
  .out_tag        (out_tag)
);

// File: tb/sstk_perm_unit_tb.sv
module sstk_perm_unit_tb;

  localparam int TAG_W = 4;
  localparam logic [2:0] F_NONE = 3'b001, F_PF = 3'b010, F_AF = 3'b100;
  localparam logic [1:0] K_FETCH = 2'b00, K_LOAD = 2'b01, K_STORE = 2'b10, K_ALT = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_pte_rwx = '0;
  logic [1:0] in_acc = '0;
  logic in_ss_acc = 1'b0, in_first_stage = 1'b0, in_ss_en = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [2:0] out_rights;
  logic out_ss_page;
  logic [2:0] out_fault;
  logic out_grant;
  logic [TAG_W-1:0] out_tag;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sstk_perm_unit #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pte_rwx(in_pte_rwx), .in_acc(in_acc), .in_ss_acc(in_ss_acc),
    .in_first_stage(in_first_stage), .in_ss_en(in_ss_en), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_rights(out_rights),
    .out_ss_page(out_ss_page), .out_fault(out_fault), .out_grant(out_grant),
    .out_tag(out_tag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Issues one request with the result register free and checks the result.
  task automatic run_one(input string req, input logic [2:0] rwx, input logic [1:0] acc,
                         input logic ss, input logic fs, input logic en,
                         input logic [2:0] e_rights, input logic e_ss_page,
                         input logic [2:0] e_fault);
    @(negedge clk);
    in_pte_rwx = rwx; in_acc = acc; in_ss_acc = ss;
    in_first_stage = fs; in_ss_en = en; in_tag = in_tag + 1'b1;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "valid", int'(out_valid), 1);
    check(req, "rights", int'(out_rights), int'(e_rights));
    check(req, "ss_page", int'(out_ss_page), int'(e_ss_page));
    check(req, "fault", int'(out_fault), int'(e_fault));
    check(req, "grant", int'(out_grant), int'(e_fault == F_NONE));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11", "valid", int'(out_valid), 0);
    check("R11", "in_ready", int'(in_ready), 1);
  endtask

  task automatic t_plain();
    run_one("R8", 3'b111, K_LOAD,  0, 1, 1, 3'b111, 0, F_NONE);
    run_one("R8", 3'b100, K_FETCH, 0, 1, 1, 3'b100, 0, F_PF);
    run_one("R8", 3'b101, K_FETCH, 0, 0, 0, 3'b101, 0, F_NONE);
    run_one("R8", 3'b110, K_ALT,   0, 1, 1, 3'b110, 0, F_NONE);
    run_one("R8", 3'b101, K_ALT,   0, 1, 1, 3'b101, 0, F_PF);
    run_one("R8", 3'b001, K_LOAD,  0, 1, 0, 3'b001, 0, F_PF);
  endtask

  task automatic t_ss_page();
    run_one("R7", 3'b010, K_LOAD,  0, 1, 1, 3'b100, 1, F_NONE);
    run_one("R6", 3'b010, K_STORE, 0, 1, 1, 3'b100, 1, F_AF);
    run_one("R6", 3'b010, K_FETCH, 0, 1, 1, 3'b100, 1, F_AF);
    run_one("R3", 3'b010, K_STORE, 1, 1, 1, 3'b110, 1, F_NONE);
    run_one("R4", 3'b010, K_FETCH, 1, 1, 1, 3'b110, 1, F_NONE);
  endtask

  task automatic t_w_only_off();
    run_one("R1", 3'b010, K_LOAD,  0, 1, 0, 3'b000, 0, F_PF);
    run_one("R1", 3'b010, K_LOAD,  0, 0, 1, 3'b000, 0, F_PF);
    run_one("R1", 3'b010, K_STORE, 1, 1, 0, 3'b000, 0, F_PF);
  endtask

  task automatic t_wx_reserved();
    run_one("R2", 3'b011, K_STORE, 0, 1, 1, 3'b000, 0, F_PF);
    run_one("R2", 3'b011, K_LOAD,  1, 0, 0, 3'b000, 0, F_PF);
  endtask

  task automatic t_ss_other();
    run_one("R5", 3'b100, K_LOAD,  1, 1, 1, 3'b100, 0, F_PF);
    run_one("R4", 3'b110, K_LOAD,  1, 1, 1, 3'b110, 0, F_NONE);
    run_one("R4", 3'b101, K_FETCH, 1, 0, 0, 3'b101, 0, F_PF);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    in_pte_rwx = 3'b011; in_acc = K_LOAD; in_ss_acc = 0; in_first_stage = 1; in_ss_en = 1;
    in_tag = 4'hA; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", "valid_A", int'(out_valid), 1);
    check("R10", "in_ready_full", int'(in_ready), 0);
    in_pte_rwx = 3'b111; in_acc = K_LOAD; in_tag = 4'hB;
    @(posedge clk);
    @(negedge clk);
    check("R10", "tag_held", int'(out_tag), 'hA);
    check("R10", "fault_held", int'(out_fault), int'(F_PF));
    out_ready = 1'b1;
    #0.5;
    check("R10", "in_ready_drain", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "tag_B", int'(out_tag), 'hB);
    check("R10", "fault_B", int'(out_fault), int'(F_NONE));
    @(posedge clk);
    @(negedge clk);
    check("R10", "empty", int'(out_valid), 0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_ss_page();
    t_w_only_off();
    t_wx_reserved();
    t_ss_other();
    t_backpressure();
    finish_up();
  end

endmodule